// File: doc/BRIEF.md
# I2C Target Controller with Automatic Address Acknowledge

This block is the target side of an I2C bus. It sits behind a small register interface for a host processor and drives open-drain SCL and SDA through output-enable pins. Once the host has loaded a 7-bit address and switched the block on, the block watches the bus for START and STOP. It compares each address byte with the programmed value and acknowledges a match on its own. It then shifts data bytes in or out, MSB first.

Each data byte is paced by one interrupt flag. After a byte has been received, or when the next byte to send is needed, the flag is set. SCL is held low after the acknowledge clock until the host clears the flag by writing 1 to it. Each direction has a mode bit that hands this pacing to a DMA request/acknowledge pair instead of the flag.

The host enables the block with four writes: clear the busy bit, load the address, connect the pads, set the enable bit. The block responds correctly when the bits are written in that order.

Top module: `i2c_tgt_auto`

## Requirements
- R1: With busy clear, enable and pad-select set, an address byte whose upper seven bits equal the programmed address is acknowledged (SDA low on the ninth clock) with no host action. With busy set (control bit 2, set at reset), the same address is not acknowledged.
- R2: Register 1 holds the target address in bits 6:0, and reads it back unchanged.
- R3: While pad-select (control bit 1) is clear, the block neither samples the bus nor drives SCL or SDA, even when the matching address is sent.
- R4: While enable (control bit 0) is clear, no address is matched and neither line is driven.
- R5: In a controller write to this target in processor mode, each received byte appears in register 2 and the flag (control bit 7, also the irq pin) is set. Register 2 reads 0 while the flag is clear.
- R6: In a controller read in processor mode, the flag is set after the address acknowledge and after every acknowledged data byte. Once the flag is cleared, the next byte sent is the content of register 3, MSB first.
- R7: Writing control with bit 7 = 1 clears the flag. While the flag or a DMA request is pending after an acknowledge clock, the block holds SCL low. It never holds SCL low with nothing pending.
- R8: Bit 0 of the address byte selects the direction (1 = read). After a non-matching address, SDA stays released until the next START, and a repeated START with the matching address is then acknowledged.
- R9: With DMA-write mode (control bit 3) set, a received byte raises dma_rx_req with the byte on dma_rx_data instead of the flag. Register 2 reads 0, and dma_ack clears the request.
- R10: With DMA-read mode (control bit 4) set, the need for a byte raises dma_tx_req instead of the flag. dma_ack captures dma_tx_data, which is the next byte sent.
- R11: A NACK from the controller after a read byte ends the transfer: SDA is released and no further request is raised.
- R12: After reset, control reads 8'h04, irq is low and neither line is driven. A STOP returns the block to idle with both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 address, 2 receive, 3 transmit |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Interrupt flag (control bit 7) |
| dma_rx_req | output | 1 | Received byte ready for the DMA engine |
| dma_rx_data | output | 8 | Received byte for the DMA engine |
| dma_tx_req | output | 1 | Next transmit byte requested from the DMA engine |
| dma_tx_data | input | 8 | Transmit byte supplied by the DMA engine |
| dma_ack | input | 1 | DMA engine has serviced the pending request |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions check properties that hold on every cycle:
- SCL is stretched only while a flag or DMA request is pending.
- Both lines stay released whenever pad-select or enable is clear.
- The flag falls only after a write-one clear.
- A DMA request rises only in its own mode and falls only after dma_ack.

Some behaviours need a full bus transaction and are shown only by the bench's scenarios:
- the acknowledge decision against address and busy;
- the order of bits and bytes in each direction;
- the receive register reading 0 when it is not valid;
- the end of a read on NACK;
- recovery on a repeated START after a mismatch.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADR_W   = 7;
    localparam int CNT_W   = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_DACK,
        ST_TXLD, ST_TX, ST_MACK, ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sh;
        logic                rw;
        logic                ackb;
    } fsm_t;

    typedef struct packed {
        logic                en;
        logic                pad;
        logic                busy;
        logic                dwr;
        logic                drd;
        logic                flag;
        logic                rxreq;
        logic                txreq;
        logic [ADR_W-1:0]    own;
        logic [BYTE_W-1:0]   rxd;
        logic [BYTE_W-1:0]   txd;
    } regs_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);
    // index 0 = SCL, index 1 = SDA; three stages: two to synchronize, one for edges
    logic [1:0] raw;
    logic [1:0] s1_d, s1_q, s2_d, s2_q, s3_d, s3_q;

    assign raw = {sda_raw, scl_raw};

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_line
            always_comb begin
                s1_d[g] = gate ? raw[g] : 1'b1;
                s2_d[g] = s1_q[g];
                s3_d[g] = s2_q[g];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 2'b11;
            s2_q <= 2'b11;
            s3_q <= 2'b11;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
            s3_q <= s3_d;
        end
    end

    assign scl_rise  =  s2_q[0] & ~s3_q[0];
    assign scl_fall  = ~s2_q[0] &  s3_q[0];
    assign sda_lvl   =  s2_q[1];
    assign start_det = ~s2_q[1] &  s3_q[1] & s2_q[0] & s3_q[0];
    assign stop_det  =  s2_q[1] & ~s3_q[1] & s2_q[0] & s3_q[0];
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_we,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              dma_ack,
    input  logic [BYTE_W-1:0] dma_tx_data,
    input  logic              ev_rx,
    input  logic              ev_tx,
    input  logic [BYTE_W-1:0] rx_byte,
    output regs_t             r
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            case (reg_addr)
                2'd0: begin
                    r_d.en   = reg_wdata[0];
                    r_d.pad  = reg_wdata[1];
                    r_d.busy = reg_wdata[2];
                    r_d.dwr  = reg_wdata[3];
                    r_d.drd  = reg_wdata[4];
                    if (reg_wdata[7]) r_d.flag = 1'b0;
                end
                2'd1: r_d.own = reg_wdata[ADR_W-1:0];
                2'd3: r_d.txd = reg_wdata;
                default: ;
            endcase
        end
        if (dma_ack) begin
            r_d.rxreq = 1'b0;
            if (r_q.txreq) begin
                r_d.txreq = 1'b0;
                r_d.txd   = dma_tx_data;
            end
        end
        // bus events win over a same-cycle clear
        if (ev_rx) begin
            r_d.rxd = rx_byte;
            if (r_q.dwr) r_d.rxreq = 1'b1;
            else         r_d.flag  = 1'b1;
        end
        if (ev_tx) begin
            if (r_q.drd) r_d.txreq = 1'b1;
            else         r_d.flag  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.busy <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = {r_q.flag, 2'b00, r_q.drd, r_q.dwr, r_q.busy, r_q.pad, r_q.en};
            2'd1:    reg_rdata = {{(BYTE_W-ADR_W){1'b0}}, r_q.own};
            2'd2:    reg_rdata = (r_q.flag && !r_q.dwr) ? r_q.rxd : '0;
            default: reg_rdata = r_q.txd;
        endcase
    end

    assign r = r_q;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              busy,
    input  logic [ADR_W-1:0]  own,
    input  logic              pending,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              ev_rx,
    output logic              ev_tx,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sda_drv,
    output logic              scl_drv
);
    fsm_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        ev_rx   = 1'b0;
        ev_tx   = 1'b0;
        sda_drv = 1'b0;
        scl_drv = 1'b0;
        case (f_q.st)
            ST_ADDR: begin
                if (scl_rise) begin
                    f_d.sh  = {f_q.sh[BYTE_W-2:0], sda_lvl};
                    f_d.cnt = f_q.cnt + 1'b1;
                end
                if (scl_fall && f_q.cnt == CNT_W'(BYTE_W)) begin
                    if (f_q.sh[BYTE_W-1:1] == own && !busy) begin
                        f_d.rw = f_q.sh[0];
                        f_d.st = ST_AACK;
                    end else begin
                        f_d.st = ST_SKIP;
                    end
                end
            end
            ST_AACK: begin
                sda_drv = 1'b1;
                if (scl_fall) begin
                    f_d.cnt = '0;
                    if (f_q.rw) begin
                        ev_tx  = 1'b1;
                        f_d.st = ST_TXLD;
                    end else begin
                        f_d.st = ST_RX;
                    end
                end
            end
            ST_RX: begin
                scl_drv = (f_q.cnt == '0) && pending;
                if (scl_rise) begin
                    f_d.sh  = {f_q.sh[BYTE_W-2:0], sda_lvl};
                    f_d.cnt = f_q.cnt + 1'b1;
                end
                if (scl_fall && f_q.cnt == CNT_W'(BYTE_W)) begin
                    ev_rx  = 1'b1;
                    f_d.st = ST_DACK;
                end
            end
            ST_DACK: begin
                sda_drv = 1'b1;
                if (scl_fall) begin
                    f_d.cnt = '0;
                    f_d.st  = ST_RX;
                end
            end
            ST_TXLD: begin
                scl_drv = pending;
                if (!pending) begin
                    f_d.sh  = tx_byte;
                    f_d.cnt = '0;
                    f_d.st  = ST_TX;
                end
            end
            ST_TX: begin
                sda_drv = ~f_q.sh[BYTE_W-1];
                if (scl_fall) begin
                    f_d.cnt = f_q.cnt + 1'b1;
                    if (f_q.cnt == CNT_W'(BYTE_W-1)) f_d.st = ST_MACK;
                    else f_d.sh = {f_q.sh[BYTE_W-2:0], 1'b0};
                end
            end
            ST_MACK: begin
                if (scl_rise) f_d.ackb = sda_lvl;
                if (scl_fall) begin
                    if (!f_q.ackb) begin
                        ev_tx  = 1'b1;
                        f_d.st = ST_TXLD;
                    end else begin
                        f_d.st = ST_SKIP;
                    end
                end
            end
            default: ;
        endcase
        if (stop_det) f_d.st = ST_IDLE;
        if (start_det) begin
            f_d.st  = ST_ADDR;
            f_d.cnt = '0;
        end
        if (!en) f_d.st = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q      <= '0;
            f_q.st   <= ST_IDLE;
            f_q.ackb <= 1'b1;
        end else begin
            f_q <= f_d;
        end
    end

    assign rx_byte = f_q.sh;
endmodule

// File: rtl/i2c_tgt_auto.sv
module i2c_tgt_auto
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_we,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq,
    output logic              dma_rx_req,
    output logic [BYTE_W-1:0] dma_rx_data,
    output logic              dma_tx_req,
    input  logic [BYTE_W-1:0] dma_tx_data,
    input  logic              dma_ack,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe
);
    regs_t             r;
    logic              scl_rise, scl_fall, sda_lvl, start_det, stop_det;
    logic              ev_rx, ev_tx, sda_drv, scl_drv, pending, live;
    logic [BYTE_W-1:0] rx_byte;

    i2c_tgt_sync u_sync (
        .clk(clk), .rst_n(rst_n), .gate(r.pad),
        .scl_raw(scl_i), .sda_raw(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_tgt_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dma_ack(dma_ack), .dma_tx_data(dma_tx_data),
        .ev_rx(ev_rx), .ev_tx(ev_tx), .rx_byte(rx_byte), .r(r)
    );

    assign pending = r.flag | r.rxreq | r.txreq;

    i2c_tgt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en(r.en), .busy(r.busy), .own(r.own),
        .pending(pending), .tx_byte(r.txd),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
        .start_det(start_det), .stop_det(stop_det),
        .ev_rx(ev_rx), .ev_tx(ev_tx), .rx_byte(rx_byte),
        .sda_drv(sda_drv), .scl_drv(scl_drv)
    );

    assign live        = r.en & r.pad;
    assign sda_oe      = sda_drv & live;
    assign scl_oe      = scl_drv & live;
    assign irq         = r.flag;
    assign dma_rx_req  = r.rxreq;
    assign dma_tx_req  = r.txreq;
    assign dma_rx_data = r.rxd;
endmodule

// File: rtl/i2c_tgt_auto_chk.sv
module i2c_tgt_auto_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       pad,
    input logic       dwr,
    input logic       drd,
    input logic [1:0] reg_addr,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic       irq,
    input logic       dma_rx_req,
    input logic       dma_tx_req,
    input logic       dma_ack,
    input logic       scl_oe,
    input logic       sda_oe
);
    p_hold_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> (irq || dma_rx_req || dma_tx_req));

    p_pad_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pad |-> (!sda_oe && !scl_oe));

    p_en_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!sda_oe && !scl_oe));

    p_flag_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_we && reg_addr == 2'd0 && reg_wdata[7]));

    p_rxreq_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_rx_req) |-> dwr);

    p_rxreq_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_rx_req) |-> $past(dma_ack));

    p_txreq_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_tx_req) |-> drd);

    p_txreq_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_tx_req) |-> $past(dma_ack));
endmodule

bind i2c_tgt_auto i2c_tgt_auto_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(r.en), .pad(r.pad), .dwr(r.dwr), .drd(r.drd),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req),
    .dma_ack(dma_ack), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_tgt_auto_test.sv
module i2c_tgt_auto_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 20;
    localparam logic [6:0] OWN = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, dma_rx_req, dma_tx_req, scl_oe, sda_oe;
    logic [7:0] dma_rx_data;
    logic [7:0] dma_tx_data = '0;
    logic       dma_ack = 1'b0;
    logic       tb_scl_low = 1'b0;
    logic       tb_sda_low = 1'b0;
    logic       scl_i, sda_i;

    int  total = 0;
    int  bad = 0;
    int  quiet_bad = 0;
    bit  quiet = 1'b0;
    bit  done = 1'b0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_i = ~(tb_scl_low | scl_oe);
    assign sda_i = ~(tb_sda_low | sda_oe);

    i2c_tgt_auto uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .dma_rx_req(dma_rx_req), .dma_rx_data(dma_rx_data),
        .dma_tx_req(dma_tx_req), .dma_tx_data(dma_tx_data), .dma_ack(dma_ack),
        .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // per-clock comparison: the model says when the target must keep off the bus
    always @(negedge clk) if (rst_n && quiet && (sda_oe || scl_oe)) quiet_bad++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic dma_pulse();
        @(negedge clk); dma_ack = 1'b1;
        @(negedge clk); dma_ack = 1'b0;
    endtask

    task automatic wait_scl_high();
        while (!scl_i) @(negedge clk);
    endtask

    task automatic bus_start();
        tb_sda_low = 1'b0; wclk(HALF);
        tb_scl_low = 1'b0; wait_scl_high(); wclk(HALF);
        tb_sda_low = 1'b1; wclk(HALF);
        tb_scl_low = 1'b1; wclk(HALF);
    endtask

    task automatic bus_stop();
        tb_sda_low = 1'b1; wclk(HALF);
        tb_scl_low = 1'b0; wait_scl_high(); wclk(HALF);
        tb_sda_low = 1'b0; wclk(HALF);
    endtask

    task automatic bit_out(input logic b);
        tb_sda_low = ~b; wclk(HALF);
        tb_scl_low = 1'b0; wait_scl_high(); wclk(HALF);
        tb_scl_low = 1'b1; wclk(HALF);
    endtask

    task automatic bit_in(output logic b);
        tb_sda_low = 1'b0; wclk(HALF);
        tb_scl_low = 1'b0; wait_scl_high(); wclk(HALF/2);
        b = sda_i; wclk(HALF/2);
        tb_scl_low = 1'b1; wclk(HALF);
    endtask

    task automatic byte_out(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(ack);
    endtask

    task automatic byte_in(output logic [7:0] d, input logic nack);
        for (int i = 7; i >= 0; i--) bit_in(d[i]);
        bit_out(nack);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       a;
        wclk(3);
        rst_n = 1'b1;
        wclk(2);
        // R12 reset state
        reg_read(2'd0, d);
        chk(d == 8'h04, "R12 ctrl reset", d, 8'h04);
        chk(!irq && !sda_oe && !scl_oe, "R12 idle outputs", {irq, sda_oe, scl_oe}, 0);

        // setup order: busy clear, address, pad, enable
        reg_write(2'd0, 8'h00);
        reg_write(2'd1, {1'b0, OWN});
        reg_write(2'd0, 8'h02);
        reg_write(2'd0, 8'h03);
        reg_read(2'd1, d);
        chk(d == {1'b0, OWN}, "R2 address readback", d, {1'b0, OWN});

        // processor-mode write of two bytes
        exp_q.push_back(8'hA5);
        exp_q.push_back(8'h3C);
        bus_start();
        byte_out({OWN, 1'b0}, a);
        chk(a == 1'b0, "R1 auto ack", a, 0);
        for (int k = 0; k < 2; k++) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            byte_out(e, a);
            chk(a == 1'b0, "R5 data ack", a, 0);
            wclk(4);
            chk(irq == 1'b1, "R5 flag set", irq, 1);
            chk(scl_oe == 1'b1, "R7 scl held", scl_oe, 1);
            reg_read(2'd2, d);
            chk(d == e, "R5 rx byte", d, e);
            reg_write(2'd0, 8'h83);
            wclk(2);
            chk(irq == 1'b0 && scl_oe == 1'b0, "R7 w1c release", {irq, scl_oe}, 0);
            reg_read(2'd2, d);
            chk(d == 8'h00, "R5 rx zero when flag clear", d, 0);
        end
        bus_stop();
        wclk(4);
        chk(!sda_oe && !scl_oe, "R12 stop releases", {sda_oe, scl_oe}, 0);

        // non-matching address, then repeated START with a match
        quiet = 1'b1;
        bus_start();
        byte_out({7'h15, 1'b0}, a);
        chk(a == 1'b1, "R8 mismatch nack", a, 1);
        byte_out(8'h00, a);
        chk(a == 1'b1, "R8 stays released", a, 1);
        quiet = 1'b0;
        bus_start();
        byte_out({OWN, 1'b0}, a);
        chk(a == 1'b0, "R8 ack after restart", a, 0);
        bus_stop();

        // busy set blocks acknowledge
        reg_write(2'd0, 8'h07);
        quiet = 1'b1;
        bus_start();
        byte_out({OWN, 1'b0}, a);
        chk(a == 1'b1, "R1 busy nack", a, 1);
        bus_stop();
        quiet = 1'b0;
        reg_write(2'd0, 8'h03);

        // processor-mode read, ACK then NACK
        exp_q.push_back(8'h96);
        exp_q.push_back(8'h5B);
        bus_start();
        byte_out({OWN, 1'b1}, a);
        chk(a == 1'b0, "R1 read ack", a, 0);
        for (int k = 0; k < 2; k++) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            wclk(4);
            chk(irq == 1'b1 && scl_oe == 1'b1, "R6 flag for tx", {irq, scl_oe}, 3);
            reg_write(2'd3, e);
            reg_write(2'd0, 8'h83);
            byte_in(d, k == 1);
            chk(d == e, "R6 tx byte", d, e);
        end
        wclk(4);
        chk(!sda_oe && !irq, "R11 nack ends read", {sda_oe, irq}, 0);
        quiet = 1'b1;
        bit_in(a);
        chk(a == 1'b1, "R11 sda released", a, 1);
        bus_stop();
        quiet = 1'b0;

        // DMA write mode
        reg_write(2'd0, 8'h0B);
        bus_start();
        byte_out({OWN, 1'b0}, a);
        byte_out(8'h71, a);
        chk(a == 1'b0, "R9 dma data ack", a, 0);
        wclk(4);
        chk(dma_rx_req && !irq, "R9 rx request", {dma_rx_req, irq}, 2);
        chk(dma_rx_data == 8'h71, "R9 rx data", dma_rx_data, 8'h71);
        reg_read(2'd2, d);
        chk(d == 8'h00, "R9 rx reg not valid", d, 0);
        dma_pulse();
        wclk(2);
        chk(!dma_rx_req && !scl_oe, "R9 ack clears", {dma_rx_req, scl_oe}, 0);
        bus_stop();

        // DMA read mode
        reg_write(2'd0, 8'h13);
        bus_start();
        byte_out({OWN, 1'b1}, a);
        wclk(4);
        chk(dma_tx_req && !irq, "R10 tx request", {dma_tx_req, irq}, 2);
        dma_tx_data = 8'hC3;
        dma_pulse();
        byte_in(d, 1'b1);
        chk(d == 8'hC3, "R10 dma tx byte", d, 8'hC3);
        wclk(4);
        chk(!dma_tx_req, "R11 no request after nack", dma_tx_req, 0);
        bus_stop();

        // pads disconnected
        reg_write(2'd0, 8'h01);
        quiet = 1'b1;
        bus_start();
        byte_out({OWN, 1'b0}, a);
        chk(a == 1'b1, "R3 pads off", a, 1);
        bus_stop();

        // controller disabled
        reg_write(2'd0, 8'h02);
        bus_start();
        byte_out({OWN, 1'b0}, a);
        chk(a == 1'b1, "R4 disabled", a, 1);
        bus_stop();
        quiet = 1'b0;

        chk(quiet_bad == 0, "R3 R4 R8 line quiet per clock", quiet_bad, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule